// File: doc/BRIEF.md
# Three-Channel Byte Packet Router

The router accepts variable-length packets one byte per clock on an 8-bit input bus. A frame strobe qualifies the bytes. The first byte of a packet is a header. Its two low bits name the destination channel and its upper six bits carry the payload length. The payload bytes follow the header. One check byte closes the packet, and it arrives in the cycle just after the strobe falls. Every byte of a packet routed to channel 0, 1 or 2 goes into that channel's 16-entry FIFO: the header, the payload and the check byte, in that order.

A packet whose destination field is 3 is consumed and thrown away. None of its bytes reaches any channel. The check byte must equal the XOR of the header and all payload bytes. When it does not, a one-cycle error pulse is raised. Each channel shows a valid flag while it holds data. A consumer drains a channel by holding that channel's read enable high, and the channel then moves one byte to its output on every rising edge. A write to a full FIFO is refused and flagged. A read from an empty FIFO does nothing. A busy output tells the sender when the byte it is about to send has no room.

Top module: `pkt_router`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) empties every channel, drops all `chanValid` bits, clears `parityErr`, `overflow` and `busy`, and returns the parser to waiting for a header, even if it was in the middle of a packet.
- R2: Input bytes are taken on the falling clock edge. A header byte taken with `inValid` high selects the channel given by its bits [1:0] (0, 1 or 2). The header, every following byte taken with `inValid` high, and the one byte taken just after `inValid` falls are stored in that channel, in arrival order. No other channel is affected.
- R3: A packet whose header bits [1:0] equal 3 is consumed up to and including its check byte and is written to no channel, channel 0 included. It raises neither `parityErr` nor `overflow`.
- R4: The check byte is compared with the XOR of the header and all payload bytes of a routed packet. On a mismatch, `parityErr` is high for exactly one cycle, starting at the rising edge after the falling edge that took the check byte.
- R5: A routed packet whose check byte matches leaves `parityErr` low.
- R6: `chanValid[i]` is high exactly while channel i holds at least one byte. On each rising edge where `chanRead[i]` and `chanValid[i]` are both high, the channel's data output takes its oldest byte, so a held read enable yields one new byte per clock.
- R7: A read enable on an empty channel changes nothing. The data output keeps its value, the channel stays not-valid and not-full, and a later packet reads back with exactly its own byte count.
- R8: Each channel holds 16 bytes. A write to a full channel is discarded, the 16 stored bytes are kept, and `overflow` pulses for one cycle for each discarded byte.
- R9: `busy` is high while a packet is in progress and its channel is full, and, between packets, while any channel is full. `busy` is low whenever all channels are empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Input bytes are taken on the falling edge; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inData | input | 8 | Packet byte stream |
| inValid | input | 1 | High for the header and the payload bytes of a packet |
| busy | output | 1 | Next byte has no room in its channel |
| parityErr | output | 1 | One-cycle pulse on a check-byte mismatch |
| overflow | output | 1 | One-cycle pulse for each write refused by a full channel |
| chanValid | output | 3 | Bit i high while channel i holds data |
| chanRead | input | 3 | Bit i is the read enable of channel i |
| chanData | output | 24 | Channel i output byte in bits [8*i+7:8*i] |

## Verification
The bench builds the router with its default FIFO depth of 16. Packets of up to fourteen payload bytes then fit whole, and each one can be sent and read back in a single burst. A 20-byte payload goes past the depth by six bytes, so the refused-write count, the busy flag during the body and between packets, and the kept prefix can all be checked exactly. The small depth also keeps the empty-read case and the mid-packet reset cheap to reach, right after reset or after a drain.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int DATA_W = 8;
  localparam int DEST_W = 2;
  localparam int NUM_CH = 3;
  localparam int SLOTS  = 1 << DEST_W;

  // strobes from the parser to the datapath
  typedef struct packed {
    logic              wrEn;     // store the captured byte
    logic [DEST_W-1:0] wrSel;    // channel to store into
    logic              parLoad;  // start a new check value with this byte
    logic              parAcc;   // fold this byte into the check value
    logic              parChk;   // this byte is the check byte
  } route_ctrl_t;
endpackage

// File: rtl/chan_fifo.sv
module chan_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wrEn,
  input  logic [W-1:0] wrData,
  input  logic         rdEn,
  output logic [W-1:0] rdData,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doWrite, doRead;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doWrite = wrEn && !full;
  assign doRead  = rdEn && !empty;

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      rdData <= '0;
    end else begin
      if (doWrite) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doRead) begin
        rdData <= mem[rdPtr];
        rdPtr  <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      end
      unique case ({doWrite, doRead})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pkt_ctrl.sv
module pkt_ctrl
  import router_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              capValid,
  input  logic [DEST_W-1:0] capDest,
  input  logic [NUM_CH-1:0] chanFull,
  output route_ctrl_t       ctrl,
  output logic              busy
);
  localparam logic [DEST_W-1:0] DROP_ADDR = DEST_W'(NUM_CH);

  typedef enum logic [1:0] { ST_HEAD, ST_BODY, ST_DROP } parse_t;

  parse_t            state, nextState;
  logic [DEST_W-1:0] destQ;
  logic [SLOTS-1:0]  fullPad;

  assign fullPad = SLOTS'(chanFull);

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_HEAD: begin
        if (capValid) begin
          if (capDest >= DROP_ADDR) begin
            nextState = ST_DROP;
          end else begin
            ctrl.wrEn    = 1'b1;
            ctrl.wrSel   = capDest;
            ctrl.parLoad = 1'b1;
            nextState    = ST_BODY;
          end
        end
      end
      ST_BODY: begin
        ctrl.wrEn  = 1'b1;
        ctrl.wrSel = destQ;
        if (capValid) begin
          ctrl.parAcc = 1'b1;
        end else begin
          ctrl.parChk = 1'b1;
          nextState   = ST_HEAD;
        end
      end
      ST_DROP: begin
        if (!capValid) nextState = ST_HEAD;
      end
      default: nextState = ST_HEAD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HEAD;
      destQ <= '0;
    end else begin
      state <= nextState;
      if (state == ST_HEAD && capValid) destQ <= capDest;
    end
  end

  assign busy = (state == ST_BODY) ? fullPad[destQ] : (|chanFull);
endmodule

// File: rtl/pkt_datapath.sv
module pkt_datapath
  import router_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        inData,
  input  logic                     inValid,
  input  route_ctrl_t              ctrl,
  input  logic [NUM_CH-1:0]        chanRead,
  output logic                     capValid,
  output logic [DEST_W-1:0]        capDest,
  output logic [NUM_CH-1:0]        chanFull,
  output logic [NUM_CH-1:0]        chanValid,
  output logic [NUM_CH*DATA_W-1:0] chanData,
  output logic                     parityErr,
  output logic                     overflow
);
  logic [DATA_W-1:0] capData;
  logic [DATA_W-1:0] parAccQ;
  logic [SLOTS-1:0]  fullPad;

  // input bytes are taken on the falling edge
  always_ff @(negedge clk) begin
    if (rst) begin
      capValid <= 1'b0;
      capData  <= '0;
    end else begin
      capValid <= inValid;
      capData  <= inData;
    end
  end

  assign capDest = capData[DEST_W-1:0];
  assign fullPad = SLOTS'(chanFull);

  always_ff @(posedge clk) begin
    if (rst) begin
      parAccQ   <= '0;
      parityErr <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      parityErr <= ctrl.parChk && (capData != parAccQ);
      overflow  <= ctrl.wrEn && fullPad[ctrl.wrSel];
      if (ctrl.parLoad)     parAccQ <= capData;
      else if (ctrl.parAcc) parAccQ <= parAccQ ^ capData;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic emptyQ;
    logic selHit;
    assign selHit = ctrl.wrEn && (ctrl.wrSel == DEST_W'(g));
    chan_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (selHit),
      .wrData (capData),
      .rdEn   (chanRead[g]),
      .rdData (chanData[g*DATA_W +: DATA_W]),
      .empty  (emptyQ),
      .full   (chanFull[g])
    );
    assign chanValid[g] = !emptyQ;
  end
endmodule

// File: rtl/pkt_router.sv
module pkt_router
  import router_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        inData,
  input  logic                     inValid,
  output logic                     busy,
  output logic                     parityErr,
  output logic                     overflow,
  output logic [NUM_CH-1:0]        chanValid,
  input  logic [NUM_CH-1:0]        chanRead,
  output logic [NUM_CH*DATA_W-1:0] chanData
);
  route_ctrl_t       ctrl;
  logic              capValid;
  logic [DEST_W-1:0] capDest;
  logic [NUM_CH-1:0] chanFull;

  pkt_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .capValid (capValid),
    .capDest  (capDest),
    .chanFull (chanFull),
    .ctrl     (ctrl),
    .busy     (busy)
  );

  pkt_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .inData    (inData),
    .inValid   (inValid),
    .ctrl      (ctrl),
    .chanRead  (chanRead),
    .capValid  (capValid),
    .capDest   (capDest),
    .chanFull  (chanFull),
    .chanValid (chanValid),
    .chanData  (chanData),
    .parityErr (parityErr),
    .overflow  (overflow)
  );
endmodule

// File: rtl/router_checker.sv
module router_checker
  import router_pkg::*;
(
  input logic                     clk,
  input logic                     rst,
  input logic                     busy,
  input logic                     parityErr,
  input logic                     overflow,
  input logic [NUM_CH-1:0]        chanValid,
  input logic [NUM_CH-1:0]        chanRead,
  input logic [NUM_CH*DATA_W-1:0] chanData
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (chanValid == '0 && !parityErr && !overflow && !busy));

  // R4
  parity_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    parityErr |=> !parityErr);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(busy));

  // R9
  busy_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (chanValid == '0) |-> !busy);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
      (!chanValid[g] && chanRead[g]) |=> $stable(chanData[g*DATA_W +: DATA_W]));
  end
endmodule

bind pkt_router router_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .parityErr (parityErr),
  .overflow  (overflow),
  .chanValid (chanValid),
  .chanRead  (chanRead),
  .chanData  (chanData)
);

// File: tb/sim_pkt_router.sv
`timescale 1ns/1ps
module sim_pkt_router;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  inData;
  logic        inValid;
  logic        busy, parityErr, overflow;
  logic [2:0]  chanValid;
  logic [2:0]  chanRead;
  logic [23:0] chanData;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pkt_router u0 (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid),
    .busy(busy), .parityErr(parityErr), .overflow(overflow),
    .chanValid(chanValid), .chanRead(chanRead), .chanData(chanData)
  );

  // vector: [14:13] dest, [12:9] payload length, [8:1] seed, [0] corrupt check byte
  localparam int NV = 6;
  localparam logic [14:0] VEC [NV] = '{
    {2'd0, 4'd3,  8'h10, 1'b0},
    {2'd1, 4'd0,  8'h00, 1'b0},
    {2'd2, 4'd13, 8'hA0, 1'b0},
    {2'd0, 4'd5,  8'h33, 1'b1},
    {2'd1, 4'd7,  8'hF0, 1'b1},
    {2'd2, 4'd1,  8'h5C, 1'b0}
  };

  logic [7:0] pkt [32];
  int         pktN;
  int         ovfSeen;
  logic       perrSeen, busySeen, perrAfter;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic build(input logic [1:0] d, input int len, input logic [7:0] seed, input bit bad);
    logic [7:0] p;
    pkt[0] = {6'(len), d};
    p = pkt[0];
    for (int i = 1; i <= len; i++) begin
      pkt[i] = seed + 8'(i * 7);
      p = p ^ pkt[i];
    end
    pkt[len + 1] = bad ? ~p : p;
    pktN = len + 2;
  endtask

  task automatic drive(input logic [7:0] d, input logic v);
    @(posedge clk); #1;
    ovfSeen += int'(overflow);
    if (parityErr) perrSeen = 1'b1;
    if (busy) busySeen = 1'b1;
    inData  = d;
    inValid = v;
  endtask

  task automatic sendPacket();
    ovfSeen = 0; perrSeen = 1'b0; busySeen = 1'b0;
    for (int i = 0; i < pktN; i++) drive(pkt[i], i < pktN - 1);
    drive(8'h00, 1'b0);
    @(posedge clk); #1;
    perrAfter = parityErr;
    ovfSeen += int'(overflow);
  endtask

  // hold read enable for n edges, compare each byte against pkt[0..n-1]
  task automatic burstRead(input int ch, input int n, input string tag);
    @(posedge clk); #1;
    chanRead[ch] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (i == n - 1) chanRead[ch] = 1'b0;
      chk(chanData[ch*8 +: 8] == pkt[i], tag, int'(chanData[ch*8 +: 8]), int'(pkt[i]));
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rst = 1'b1; inData = '0; inValid = 1'b0; chanRead = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1 reset state
    chk(chanValid == 3'b000, "R1 valid after reset", int'(chanValid), 0);
    chk(!busy && !parityErr && !overflow, "R1 flags after reset",
        int'({busy, parityErr, overflow}), 0);

    // R7 empty read: nothing moves
    @(posedge clk); #1 chanRead = 3'b100;
    repeat (4) @(posedge clk);
    #1;
    chk(chanData[23:16] == 8'h00, "R7 data held on empty read", int'(chanData[23:16]), 0);
    chk(chanValid == 3'b000 && !busy, "R7 no valid/full on empty read",
        int'({busy, chanValid}), 0);
    chanRead = '0;
    build(2'd2, 2, 8'h71, 1'b0);
    sendPacket();
    burstRead(2, 4, "R7 packet after empty read");
    @(posedge clk); #1;
    chk(chanValid[2] == 1'b0, "R7 count exact after drain", int'(chanValid[2]), 0);

    // R2 R4 R5 R6 table of packets
    for (int v = 0; v < NV; v++) begin
      logic [1:0] d;
      d = VEC[v][14:13];
      build(d, int'(VEC[v][12:9]), VEC[v][8:1], VEC[v][0]);
      sendPacket();
      if (VEC[v][0]) chk(perrSeen == 1'b1, "R4 mismatch pulse", int'(perrSeen), 1);
      else           chk(perrSeen == 1'b0, "R5 match no pulse", int'(perrSeen), 0);
      chk(perrAfter == 1'b0, "R4 pulse one cycle", int'(perrAfter), 0);
      chk(chanValid == (3'b001 << d), "R2 only dest valid", int'(chanValid), int'(3'b001 << d));
      burstRead(int'(d), pktN, "R6 R2 burst byte");
      @(posedge clk); #1;
      chk(chanValid == 3'b000, "R6 valid drops after drain", int'(chanValid), 0);
    end

    // R3 dropped packet, then a clean packet on channel 0
    build(2'd3, 4, 8'h22, 1'b1);
    sendPacket();
    chk(chanValid == 3'b000, "R3 nothing stored", int'(chanValid), 0);
    chk(perrSeen == 1'b0 && ovfSeen == 0, "R3 no flags", int'(perrSeen) + ovfSeen, 0);
    build(2'd0, 2, 8'h09, 1'b0);
    sendPacket();
    burstRead(0, 4, "R3 channel 0 holds only next packet");
    @(posedge clk); #1;
    chk(chanValid == 3'b000, "R3 channel 0 exact length", int'(chanValid), 0);

    // R8 R9 overflow: 22 bytes into a 16-entry channel
    build(2'd1, 20, 8'h40, 1'b0);
    sendPacket();
    chk(ovfSeen == 6, "R8 refused writes", ovfSeen, 6);
    chk(busySeen == 1'b1, "R9 busy during body", int'(busySeen), 1);
    chk(busy == 1'b1, "R9 busy between packets", int'(busy), 1);
    burstRead(1, 16, "R8 kept prefix");
    @(posedge clk); #1;
    chk(chanValid == 3'b000 && !busy, "R8 empty after 16 reads", int'({busy, chanValid}), 0);

    // R1 reset in mid-packet
    build(2'd0, 6, 8'h11, 1'b0);
    drive(pkt[0], 1'b1);
    drive(pkt[1], 1'b1);
    drive(pkt[2], 1'b1);
    @(posedge clk); #1 rst = 1'b1; inValid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    chk(chanValid == 3'b000, "R1 mid-packet reset clears", int'(chanValid), 0);
    build(2'd1, 3, 8'h66, 1'b0);
    sendPacket();
    chk(chanValid == 3'b010 && !perrSeen, "R1 parser restarts at header",
        int'(chanValid), 2);
    burstRead(1, 5, "R1 packet after reset");

    finishRun();
  end
endmodule